// File: doc/BRIEF.md
# Serial OLED Command/Data Decoder

This block sits behind the byte engine of a two-wire serial slave and turns the write stream of a small monochrome OLED panel into frame-memory writes and display settings. Each accepted byte arrives with a one-cycle `byte_valid` strobe; the end of a bus transaction arrives as a one-cycle `stop_pulse`. The first byte of each access is a control byte that picks command or data interpretation for what follows.

In data mode every byte lands in an internal frame store organised as 8 pages of 132 columns, each byte holding eight vertical pixels, and the column pointer moves right after each store until it reaches the right edge, where further bytes are thrown away. In command mode a single opcode is decoded. It moves the column or page pointer, sets the scan start line, or changes the mirror, all-pixels-on, inverse and enable flags. A group of configuration opcodes owes one parameter byte, which is swallowed. A scanout block reads the frame store through a synchronous read port and clears a sticky redraw flag once it has refreshed the panel.

Top module: `oled_cmd_decoder`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the decoder is idle, with column 0, page 0, start line 0, all four display flags 0, redraw 0 and both error pulses 0.
- R2: In idle, byte 0x80 selects command mode and byte 0x40 selects data mode; any other byte drives err_ctrl high for exactly the one cycle after that byte and the decoder stays idle.
- R3: In data mode, a byte received while the column is below 132 is stored at frame address column + 132*page and the column increments by one; rd_data shows the byte at rd_addr one clock after rd_addr is presented.
- R4: In data mode, a byte received while the column is 132 or more is not stored anywhere and the column keeps its value (no wrap to the next page).
- R5: Data mode stays active for any number of bytes until stop_pulse, which returns the decoder to idle so that the next byte is again a control byte.
- R6: In command mode exactly one opcode is decoded, after which the decoder is idle and needs a new control byte.
- R7: Opcodes 0x00 to 0x0F replace column bits [3:0] with opcode bits [3:0]; opcodes 0x10 to 0x20 replace column bits [7:4] with opcode bits [3:0].
- R8: Opcodes 0xB0 to 0xBF set the page to opcode bits [2:0].
- R9: Opcodes 0x40 to 0x7F set the start line to opcode bits [5:0].
- R10: Opcode pairs with bit 0 as the new value: 0xA0/0xA1 mirror, 0xA4/0xA5 entire_on, 0xA6/0xA7 inverse, 0xAE/0xAF disp_en.
- R11: Opcodes 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA, 0xDB change no output and make the decoder owe one parameter byte; the next byte received in command mode (after a new 0x80 control byte) is discarded, command mode stays active, and the byte after it is decoded as an opcode.
- R12: Opcodes 0xC0 to 0xC8 and 0xE3 change nothing; any opcode not listed in R7 to R12 drives err_unknown high for the one cycle after it and changes nothing else.
- R13: redraw is set by every byte that R3 stores, stays set until redraw_clr, and a store in the same cycle as redraw_clr leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | One-cycle strobe qualifying byte_data |
| byte_data | input | 8 | Received write byte |
| stop_pulse | input | 1 | One-cycle end-of-transaction pulse |
| redraw_clr | input | 1 | Scanout acknowledgement clearing redraw |
| rd_addr | input | 11 | Frame store read address (column + 132*page) |
| rd_data | output | 8 | Frame store byte, one clock after rd_addr |
| col_ptr | output | 8 | Current column pointer |
| page_ptr | output | 3 | Current page pointer |
| start_line | output | 6 | Scan start line |
| mirror | output | 1 | Horizontal mirror flag |
| entire_on | output | 1 | All-pixels-on flag |
| inverse | output | 1 | Inverse video flag |
| disp_en | output | 1 | Display enable flag |
| redraw | output | 1 | Sticky frame-changed flag |
| err_ctrl | output | 1 | Pulse: bad control byte in idle |
| err_unknown | output | 1 | Pulse: unrecognised opcode |

## Verification
The bound checker watches every cycle for the mode sequencing: a stop always lands in idle, a decoded opcode always returns to idle, a swallowed parameter keeps command mode, a bad control byte raises err_ctrl and stays idle, the column advances by one on an in-range data byte and holds at the right edge, redraw never drops without a clear, and err_unknown only follows a command-mode byte. What the checker cannot see is where bytes land and what each opcode writes: the bench scenarios read the frame store back to prove addressing and the absence of wrap-around writes, and walk each opcode group, including the 0x20 and 0x30 boundaries and a parameter byte that looks like a valid opcode.

// File: rtl/oled_dec_pkg.sv
// Package: shared types for the serial OLED command/data decoder.
// Assumes: byte-wide input stream, control byte values fixed by the panel protocol.
package oled_dec_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_DATA = 2'd1,
        MODE_CMD  = 2'd2
    } dec_mode_e;

    typedef enum logic [3:0] {
        OP_COL_LO,
        OP_COL_HI,
        OP_START,
        OP_PARAM,
        OP_MIRROR,
        OP_ALLON,
        OP_INVERT,
        OP_ENABLE,
        OP_PAGE,
        OP_NOP,
        OP_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     level;
    } op_dec_t;

    localparam logic [7:0] CTRL_CMD  = 8'h80;
    localparam logic [7:0] CTRL_DATA = 8'h40;

endpackage

// File: rtl/oled_opcode_decode.sv
// Module: oled_opcode_decode
// Classifies one command byte into an action kind plus the flag level (bit 0).
// Assumes: purely combinational; the caller qualifies it with its own strobe.
module oled_opcode_decode
    import oled_dec_pkg::*;
(
    input  logic [7:0] opcode,
    output op_dec_t    dec
);

    // Range checks first, then the discrete opcodes.
    always_comb begin
        dec.level = opcode[0];
        dec.kind  = OP_BAD;
        if (opcode <= 8'h0F) begin
            dec.kind = OP_COL_LO;
        end else if (opcode <= 8'h20) begin
            dec.kind = OP_COL_HI;
        end else if (opcode >= 8'h40 && opcode <= 8'h7F) begin
            dec.kind = OP_START;
        end else if (opcode >= 8'hB0 && opcode <= 8'hBF) begin
            dec.kind = OP_PAGE;
        end else if (opcode >= 8'hC0 && opcode <= 8'hC8) begin
            dec.kind = OP_NOP;
        end else begin
            case (opcode)
                8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
                8'hD8, 8'hD9, 8'hDA, 8'hDB: dec.kind = OP_PARAM;
                8'hA0, 8'hA1:               dec.kind = OP_MIRROR;
                8'hA4, 8'hA5:               dec.kind = OP_ALLON;
                8'hA6, 8'hA7:               dec.kind = OP_INVERT;
                8'hAE, 8'hAF:               dec.kind = OP_ENABLE;
                8'hE3:                      dec.kind = OP_NOP;
                default:                    dec.kind = OP_BAD;
            endcase
        end
    end

endmodule

// File: rtl/oled_mode_fsm.sv
// Module: oled_mode_fsm
// Tracks idle/data/command mode and the owed-parameter marker; flags bad control bytes.
// Assumes: stop_pulse and byte_valid are single-cycle; stop wins for the next mode.
module oled_mode_fsm
    import oled_dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      byte_valid,
    input  logic [7:0] byte_data,
    input  logic      stop_pulse,
    input  op_kind_e  op_kind,
    output dec_mode_e mode,
    output logic      skip_owed,
    output logic      err_ctrl
);

    // Mode transitions, parameter bookkeeping and control-byte error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= MODE_IDLE;
            skip_owed <= 1'b0;
            err_ctrl  <= 1'b0;
        end else begin
            err_ctrl <= 1'b0;
            if (byte_valid) begin
                case (mode)
                    MODE_IDLE: begin
                        if (byte_data == CTRL_CMD)
                            mode <= MODE_CMD;
                        else if (byte_data == CTRL_DATA)
                            mode <= MODE_DATA;
                        else
                            err_ctrl <= 1'b1;
                    end
                    MODE_CMD: begin
                        if (skip_owed) begin
                            skip_owed <= 1'b0;
                        end else begin
                            mode      <= MODE_IDLE;
                            skip_owed <= (op_kind == OP_PARAM);
                        end
                    end
                    default: ;
                endcase
            end
            if (stop_pulse)
                mode <= MODE_IDLE;
        end
    end

endmodule

// File: rtl/oled_frame_mem.sv
// Module: oled_frame_mem
// Page-organised frame store: one write port, one synchronous read port.
// Assumes: no reset on contents; write address is always in range.
module oled_frame_mem #(
    parameter int DEPTH = 1056,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] store [DEPTH];

    // Write one byte when enabled.
    always_ff @(posedge clk) begin
        if (wr_en)
            store[wr_addr] <= wr_data;
    end

    // Registered read for the scanout side.
    always_ff @(posedge clk) begin
        rd_data <= store[rd_addr];
    end

endmodule

// File: rtl/oled_cmd_decoder.sv
// Module: oled_cmd_decoder (top)
// Decodes a control-framed byte stream into frame-store writes, pointer moves and
// display flags. Assumes bytes come from an external serial slave engine, one per
// byte_valid strobe, and that the scanout block owns redraw_clr and the read port.
module oled_cmd_decoder
    import oled_dec_pkg::*;
#(
    parameter int NUM_COLS  = 132,
    parameter int NUM_PAGES = 8,
    parameter int START_W   = 6,
    localparam int COL_W     = 8,
    localparam int PAGE_W    = $clog2(NUM_PAGES),
    localparam int MEM_DEPTH = NUM_COLS * NUM_PAGES,
    localparam int AW        = $clog2(MEM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_valid,
    input  logic [7:0]         byte_data,
    input  logic               stop_pulse,
    input  logic               redraw_clr,
    input  logic [AW-1:0]      rd_addr,
    output logic [7:0]         rd_data,
    output logic [COL_W-1:0]   col_ptr,
    output logic [PAGE_W-1:0]  page_ptr,
    output logic [START_W-1:0] start_line,
    output logic               mirror,
    output logic               entire_on,
    output logic               inverse,
    output logic               disp_en,
    output logic               redraw,
    output logic               err_ctrl,
    output logic               err_unknown
);

    localparam logic [COL_W-1:0] COL_LIMIT = COL_W'(NUM_COLS);

    dec_mode_e     mode_q;
    logic          skip_owed;
    op_dec_t       dec;
    logic          data_strobe;
    logic          op_strobe;
    logic          store_en;
    logic [AW-1:0] wr_addr;

    oled_opcode_decode u_decode (
        .opcode (byte_data),
        .dec    (dec)
    );

    oled_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .stop_pulse (stop_pulse),
        .op_kind    (dec.kind),
        .mode       (mode_q),
        .skip_owed  (skip_owed),
        .err_ctrl   (err_ctrl)
    );

    // Strobes qualifying a data byte, an in-range store and a decodable opcode.
    always_comb begin
        data_strobe = byte_valid && (mode_q == MODE_DATA);
        op_strobe   = byte_valid && (mode_q == MODE_CMD) && !skip_owed;
        store_en    = data_strobe && (col_ptr < COL_LIMIT);
        wr_addr     = AW'(col_ptr) + AW'(page_ptr) * AW'(NUM_COLS);
    end

    oled_frame_mem #(
        .DEPTH (MEM_DEPTH),
        .DW    (8)
    ) u_mem (
        .clk     (clk),
        .wr_en   (store_en),
        .wr_addr (wr_addr),
        .wr_data (byte_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Pointer, start-line and flag updates from data stores and opcodes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_ptr     <= '0;
            page_ptr    <= '0;
            start_line  <= '0;
            mirror      <= 1'b0;
            entire_on   <= 1'b0;
            inverse     <= 1'b0;
            disp_en     <= 1'b0;
            err_unknown <= 1'b0;
        end else begin
            err_unknown <= 1'b0;
            if (store_en)
                col_ptr <= col_ptr + 1'b1;
            if (op_strobe) begin
                case (dec.kind)
                    OP_COL_LO: col_ptr    <= {col_ptr[7:4], byte_data[3:0]};
                    OP_COL_HI: col_ptr    <= {byte_data[3:0], col_ptr[3:0]};
                    OP_START:  start_line <= byte_data[START_W-1:0];
                    OP_PAGE:   page_ptr   <= byte_data[PAGE_W-1:0];
                    OP_MIRROR: mirror     <= dec.level;
                    OP_ALLON:  entire_on  <= dec.level;
                    OP_INVERT: inverse    <= dec.level;
                    OP_ENABLE: disp_en    <= dec.level;
                    OP_BAD:    err_unknown <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Sticky redraw: set by any store, cleared by scanout, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            redraw <= 1'b0;
        else if (store_en)
            redraw <= 1'b1;
        else if (redraw_clr)
            redraw <= 1'b0;
    end

endmodule

// File: rtl/oled_cmd_decoder_chk.sv
// Module: oled_cmd_decoder_chk
// Cycle-by-cycle properties of the decoder, attached to the top through bind.
// Assumes: connected to the top's ports plus its mode and owed-parameter state.
module oled_cmd_decoder_chk
    import oled_dec_pkg::*;
#(
    parameter int NUM_COLS = 132
) (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input logic [7:0] byte_data,
    input logic       stop_pulse,
    input logic       redraw_clr,
    input logic [7:0] col_ptr,
    input logic       redraw,
    input logic       err_ctrl,
    input logic       err_unknown,
    input dec_mode_e  mode,
    input logic       skip_owed
);

    localparam logic [7:0] LIM = 8'(NUM_COLS);

    AST_CTRL_BAD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && mode == MODE_IDLE && byte_data != CTRL_CMD && byte_data != CTRL_DATA
        |=> err_ctrl && mode == MODE_IDLE); // R2

    AST_DATA_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && mode == MODE_DATA && col_ptr < LIM
        |=> col_ptr == $past(col_ptr) + 8'd1); // R3

    AST_COL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && mode == MODE_DATA && col_ptr >= LIM
        |=> $stable(col_ptr)); // R4

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> mode == MODE_IDLE); // R5

    AST_CMD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && mode == MODE_CMD && !skip_owed
        |=> mode == MODE_IDLE); // R6

    AST_PARAM_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && mode == MODE_CMD && skip_owed && !stop_pulse
        |=> mode == MODE_CMD && !skip_owed); // R11

    AST_UNKNOWN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        err_unknown |-> $past(byte_valid) && $past(mode) == MODE_CMD); // R12

    AST_REDRAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        redraw && !redraw_clr |=> redraw); // R13

endmodule

bind oled_cmd_decoder oled_cmd_decoder_chk #(.NUM_COLS(NUM_COLS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .stop_pulse  (stop_pulse),
    .redraw_clr  (redraw_clr),
    .col_ptr     (col_ptr),
    .redraw      (redraw),
    .err_ctrl    (err_ctrl),
    .err_unknown (err_unknown),
    .mode        (mode_q),
    .skip_owed   (skip_owed)
);

// File: tb/oled_cmd_decoder_tb.sv
// Directed bench for oled_cmd_decoder: one task per scenario, each checking itself.
module oled_cmd_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        stop_pulse = 1'b0;
    logic        redraw_clr = 1'b0;
    logic [10:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic [7:0]  col_ptr;
    logic [2:0]  page_ptr;
    logic [5:0]  start_line;
    logic        mirror, entire_on, inverse, disp_en, redraw, err_ctrl, err_unknown;

    int n_checks = 0;
    int n_fail   = 0;

    oled_cmd_decoder u_dut (
        .clk (clk), .rst_n (rst_n), .byte_valid (byte_valid), .byte_data (byte_data),
        .stop_pulse (stop_pulse), .redraw_clr (redraw_clr), .rd_addr (rd_addr),
        .rd_data (rd_data), .col_ptr (col_ptr), .page_ptr (page_ptr),
        .start_line (start_line), .mirror (mirror), .entire_on (entire_on),
        .inverse (inverse), .disp_en (disp_en), .redraw (redraw),
        .err_ctrl (err_ctrl), .err_unknown (err_unknown)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle; outputs are then sampled at the following falling edge.
    task automatic drive(input logic v, input logic [7:0] b, input logic stp, input logic clr);
        @(negedge clk);
        byte_valid = v; byte_data = b; stop_pulse = stp; redraw_clr = clr;
        @(negedge clk);
        byte_valid = 1'b0; stop_pulse = 1'b0; redraw_clr = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        drive(1'b1, b, 1'b0, 1'b0);
    endtask

    task automatic stop_txn();
        drive(1'b0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic cmd(input logic [7:0] op);
        send(8'h80);
        send(op);
    endtask

    task automatic read_mem(input int addr, output logic [7:0] val);
        @(negedge clk);
        rd_addr = 11'(addr);
        @(negedge clk);
        val = rd_data;
    endtask

    task automatic t_reset();
        check("R1 col", col_ptr, 0);
        check("R1 page", page_ptr, 0);
        check("R1 start", start_line, 0);
        check("R1 flags", {mirror, entire_on, inverse, disp_en}, 0);
        check("R1 redraw/errs", {redraw, err_ctrl, err_unknown}, 0);
    endtask

    task automatic t_ctrl_error();
        send(8'h55);
        check("R2 err_ctrl pulse", err_ctrl, 1);
        @(negedge clk);
        check("R2 err_ctrl one cycle", err_ctrl, 0);
        cmd(8'hAF);
        check("R2 idle after bad byte, cmd works", disp_en, 1);
        check("R2 no err on 0x80", err_ctrl, 0);
        cmd(8'hAE);
        check("R10 disp_en clear", disp_en, 0);
    endtask

    task automatic t_data_write();
        logic [7:0] v;
        cmd(8'hB2); cmd(8'h05); cmd(8'h10);
        check("R8 page", page_ptr, 2);
        check("R7 col", col_ptr, 5);
        send(8'h40); send(8'hA5); send(8'h3C);
        check("R3 col advanced", col_ptr, 7);
        check("R13 redraw set", redraw, 1);
        stop_txn();
        read_mem(2*132+5, v);
        check("R3 mem p2c5", v, 8'hA5);
        read_mem(2*132+6, v);
        check("R3 mem p2c6", v, 8'h3C);
    endtask

    task automatic t_col_limit();
        logic [7:0] v;
        cmd(8'hB3); cmd(8'h00); cmd(8'h10);
        send(8'h40); send(8'h99); stop_txn();
        cmd(8'hB2); cmd(8'h03); cmd(8'h18);
        check("R7 col hi nibble", col_ptr, 8'h83);
        send(8'h40); send(8'h11); send(8'h22);
        check("R4 col reaches 132", col_ptr, 132);
        send(8'h33);
        check("R4 col holds", col_ptr, 132);
        stop_txn();
        read_mem(2*132+131, v);
        check("R4 last column stored", v, 8'h11);
        read_mem(3*132, v);
        check("R4 no wrap into next page", v, 8'h99);
        cmd(8'h20);
        check("R7 opcode 0x20 high nibble", col_ptr, 8'h04);
    endtask

    task automatic t_stop();
        send(8'h40); send(8'h44);
        check("R5 data mode col", col_ptr, 5);
        stop_txn();
        send(8'hAF);
        check("R5 idle after stop", err_ctrl, 1);
        check("R5 byte not decoded", disp_en, 0);
    endtask

    task automatic t_one_opcode();
        cmd(8'hA1);
        check("R6 opcode applied", mirror, 1);
        send(8'hA7);
        check("R6 idle after opcode", err_ctrl, 1);
        check("R6 second byte not decoded", inverse, 0);
    endtask

    task automatic t_flags();
        cmd(8'hA0); check("R10 mirror clear", mirror, 0);
        cmd(8'hA5); check("R10 entire_on set", entire_on, 1);
        cmd(8'hA4); check("R10 entire_on clear", entire_on, 0);
        cmd(8'hA7); check("R10 inverse set", inverse, 1);
        cmd(8'hA6); check("R10 inverse clear", inverse, 0);
        cmd(8'hAF); check("R10 disp_en set", disp_en, 1);
        cmd(8'hAE); check("R10 disp_en clear", disp_en, 0);
    endtask

    task automatic t_start();
        cmd(8'h6B); check("R9 start line", start_line, 6'h2B);
        cmd(8'h40); check("R9 start line zero", start_line, 0);
    endtask

    task automatic t_param();
        cmd(8'h81);
        check("R11 param opcode no error", {err_ctrl, err_unknown}, 0);
        send(8'h80);
        send(8'hAF);
        check("R11 parameter discarded", disp_en, 0);
        send(8'hA1);
        check("R11 cmd mode kept, opcode decoded", mirror, 1);
        check("R11 no ctrl error", err_ctrl, 0);
        send(8'hA6);
        check("R11 idle after decoded opcode", err_ctrl, 1);
        cmd(8'hD3);
        send(8'h80);
        send(8'h05);
        check("R11 column untouched by parameter", col_ptr, 5);
        send(8'hA0);
        check("R11 following opcode", mirror, 0);
    endtask

    task automatic t_nop_unknown();
        cmd(8'hE3);
        check("R12 0xE3 no error", err_unknown, 0);
        cmd(8'hC4);
        check("R12 0xC4 no error", err_unknown, 0);
        check("R12 nop leaves state", {col_ptr, 1'(mirror), 1'(inverse)}, {8'd5, 2'b00});
        cmd(8'hA2);
        check("R12 unknown pulse", err_unknown, 1);
        @(negedge clk);
        check("R12 unknown one cycle", err_unknown, 0);
        cmd(8'h30);
        check("R12 0x30 unknown", err_unknown, 1);
        check("R12 unknown leaves column", col_ptr, 5);
    endtask

    task automatic t_redraw();
        drive(1'b0, 8'h00, 1'b0, 1'b1);
        check("R13 redraw cleared", redraw, 0);
        cmd(8'hB0); cmd(8'h00); cmd(8'h10);
        send(8'h40);
        drive(1'b1, 8'h5A, 1'b0, 1'b1);
        check("R13 set wins over clear", redraw, 1);
        stop_txn();
        drive(1'b0, 8'h00, 1'b0, 1'b1);
        cmd(8'h05); cmd(8'h18);
        send(8'h40); send(8'h77);
        check("R13 dropped byte no redraw", redraw, 0);
        stop_txn();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_error();
        t_data_write();
        t_col_limit();
        t_stop();
        t_one_opcode();
        t_flags();
        t_start();
        t_param();
        t_nop_unknown();
        t_redraw();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule